// File: doc/BRIEF.md
# Quaternary Short Uplink Scrambling Code Generator

This block produces the short complex scrambling code that repeats every 256 chips and is used on an uplink dedicated channel. A 24-bit code number selects the code. The low byte seeds a shift register with eight quaternary stages and a mod-4 feedback. The middle byte and the high byte seed two binary shift registers with eight stages each. Each chip is the mod-4 sum of the quaternary head and twice each binary head. The recursion yields 255 chips, and a 256th chip, equal to chip 0, completes the period.

Each quaternary chip value is mapped to two binary sequences. The in-phase output carries the first sequence. The quadrature output carries the first sequence multiplied by an alternating sign and by the second sequence taken at the even chip of the current pair. A pulse on the load input captures a new code number and restarts at chip 0. The chip enable input moves the generator forward by one chip. At the end of a period the generator reseeds itself from the stored code number, so a 38400-chip frame is simply 150 back-to-back periods.

Top module: `qscr_short_code_gen`

## Requirements
- R1: After reset the generator behaves as if code number 0 had just been loaded: chip index 0, so both output bits are 1 (chip value 1).
- R2: A load pulse stores the code number and presents chip 0 of that code after the next rising edge. A load pulse takes priority over a simultaneous chip enable.
- R3: The quaternary sequence starts as a(0) = 2*n0+1 mod 4 and a(k) = 2*nk mod 4 for k = 1..7. It continues as a(k) = 3a(k-3) + a(k-5) + 3a(k-6) + 2a(k-7) + 3a(k-8) mod 4.
- R4: The first binary sequence starts from code bits 8..15 (b(k) = n(8+k)) and continues as b(k) = b(k-1) xor b(k-3) xor b(k-7) xor b(k-8).
- R5: The second binary sequence starts from code bits 16..23 (d(k) = n(16+k)) and continues as d(k) = d(k-1) xor d(k-3) xor d(k-4) xor d(k-8).
- R6: For chips 0..254 the chip value is z = a + 2b + 2d mod 4.
- R7: Chip 255 of every period carries the same value as chip 0.
- R8: A chip enable at chip 255 returns the generator to chip 0, reseeded from the stored code number, so the periods repeat exactly.
- R9: The in-phase bit is the first mapped sequence c1. Chip values 1 and 2 give -1, and chip values 0 and 3 give +1.
- R10: The quadrature bit equals c1(i) * (-1)^i * c2(2*floor(i/2)). The second mapped sequence c2 is -1 for chip values 2 and 3 and +1 for 0 and 1.
- R11: While chip enable and load are both low, the chip index and both output bits hold their values.
- R12: Each output bit encodes +1 as 0 and -1 as 1. The products in R10 are therefore exclusive-ORs of these bits, with the sign (-1)^i given by bit 0 of the chip index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Capture code number and restart at chip 0 |
| code_i | input | 24 | Code number n |
| chip_en_i | input | 1 | Advance by one chip |
| i_bit_o | output | 1 | In-phase chip bit (0 = +1, 1 = -1) |
| q_bit_o | output | 1 | Quadrature chip bit (0 = +1, 1 = -1) |

## Verification
Both output bits are combinational views of registered state. A load or a chip enable seen at a rising edge is therefore reflected in the outputs right after that same edge, one cycle after the stimulus is driven. The bench drives inputs on the falling edge and queues the expected pair for the state that will follow the next rising edge. The monitor pops one entry 1 ns after each rising edge, so every comparison lands in the cycle where the result is due. The expected chips come from a software model that expands the three recursions over whole 255-entry arrays and appends chip 0 as chip 255.

// File: rtl/qscr_pkg.sv
package qscr_pkg;
  localparam int STAGES  = 8;
  localparam int CODE_W  = 3 * STAGES;
  localparam int PERIOD  = 256;
  localparam int IDX_W   = $clog2(PERIOD);
  localparam logic [STAGES-1:0] B_TAPS = 8'hA3;  // stages 0,1,5,7
  localparam logic [STAGES-1:0] D_TAPS = 8'hB1;  // stages 0,4,5,7

  typedef logic [1:0] quat_t;

  // Feedback of the quaternary register; st holds a(i..i+7), element k in [2k+1:2k].
  function automatic quat_t quat_feedback(input logic [2*STAGES-1:0] st);
    quat_t s0, s1, s2, s3, s5;
    s0 = st[1:0];
    s1 = st[3:2];
    s2 = st[5:4];
    s3 = st[7:6];
    s5 = st[11:10];
    return quat_t'((s5 * 2'd3) + s3 + (s2 * 2'd3) + {s1[0], 1'b0} + (s0 * 2'd3));
  endfunction

  function automatic quat_t z_combine(input quat_t a, input logic b, input logic d);
    return quat_t'(a + {b, 1'b0} + {d, 1'b0});
  endfunction

  function automatic logic c1_bit(input quat_t z);
    return z[1] ^ z[0];
  endfunction

  function automatic logic c2_bit(input quat_t z);
    return z[1];
  endfunction
endpackage

// File: rtl/qscr_quat_lfsr.sv
module qscr_quat_lfsr
  import qscr_pkg::*;
#(
  parameter int LEN = STAGES
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [LEN-1:0] seed_i,
  input  logic           shift_i,
  output quat_t          head_o
);
  logic [2*LEN-1:0] state_q;
  logic [2*LEN-1:0] seed_vec;

  genvar k;
  generate
    for (k = 0; k < LEN; k++) begin : g_seed
      if (k == 0) begin : g_first
        assign seed_vec[1:0] = {seed_i[0], 1'b1};
      end else begin : g_rest
        assign seed_vec[2*k+1:2*k] = {seed_i[k], 1'b0};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= {{(2*LEN-2){1'b0}}, 2'b01};
    end else if (load_i) begin
      state_q <= seed_vec;
    end else if (shift_i) begin
      state_q <= {quat_feedback(state_q), state_q[2*LEN-1:2]};
    end
  end

  assign head_o = state_q[1:0];

  p_shift_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> head_o == $past(state_q[3:2]));
  p_seed_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> head_o == {$past(seed_i[0]), 1'b1});
endmodule

// File: rtl/qscr_bin_lfsr.sv
module qscr_bin_lfsr
  import qscr_pkg::*;
#(
  parameter int             LEN  = STAGES,
  parameter logic [LEN-1:0] TAPS = B_TAPS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [LEN-1:0] seed_i,
  input  logic           shift_i,
  output logic           head_o
);
  logic [LEN-1:0] state_q;
  logic           fb;

  assign fb = ^(state_q & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (load_i) begin
      state_q <= seed_i;
    end else if (shift_i) begin
      state_q <= {fb, state_q[LEN-1:1]};
    end
  end

  assign head_o = state_q[0];

  p_shift_bin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> state_q[LEN-2:0] == $past(state_q[LEN-1:1]));
  p_seed_bin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> state_q == $past(seed_i));
endmodule

// File: rtl/qscr_chip_mapper.sv
module qscr_chip_mapper
  import qscr_pkg::*;
(
  input  quat_t z_i,
  input  logic  odd_i,
  input  logic  c2_hold_i,
  output logic  i_bit_o,
  output logic  q_bit_o,
  output logic  c2_now_o,
  output logic  c2_used_o
);
  logic c1;

  always_comb begin
    c1        = c1_bit(z_i);
    c2_now_o  = c2_bit(z_i);
    c2_used_o = odd_i ? c2_hold_i : c2_now_o;
    i_bit_o   = c1;
    q_bit_o   = c1 ^ odd_i ^ c2_used_o;
  end
endmodule

// File: rtl/qscr_short_code_gen.sv
module qscr_short_code_gen
  import qscr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              chip_en_i,
  output logic              i_bit_o,
  output logic              q_bit_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PERIOD - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [CODE_W-1:0] code_q;
  quat_t             z0_q;
  logic              c2_hold_q;

  logic              wrap_pt, advance, reload, shift;
  logic [CODE_W-1:0] seed;
  quat_t             a_head, z_gen, z_cur, z_seed;
  logic              b_head, d_head;
  logic              c2_now, c2_used;

  assign wrap_pt = (idx_q == LAST_IDX);
  assign advance = chip_en_i & ~load_i;
  assign reload  = load_i | (advance & wrap_pt);
  assign shift   = advance & ~wrap_pt;
  assign seed    = load_i ? code_i : code_q;
  assign z_seed  = z_combine({seed[0], 1'b1}, seed[STAGES], seed[2*STAGES]);

  qscr_quat_lfsr #(.LEN(STAGES)) u_a (
    .clk(clk), .rst_n(rst_n), .load_i(reload),
    .seed_i(seed[STAGES-1:0]), .shift_i(shift), .head_o(a_head)
  );

  qscr_bin_lfsr #(.LEN(STAGES), .TAPS(B_TAPS)) u_b (
    .clk(clk), .rst_n(rst_n), .load_i(reload),
    .seed_i(seed[2*STAGES-1:STAGES]), .shift_i(shift), .head_o(b_head)
  );

  qscr_bin_lfsr #(.LEN(STAGES), .TAPS(D_TAPS)) u_d (
    .clk(clk), .rst_n(rst_n), .load_i(reload),
    .seed_i(seed[3*STAGES-1:2*STAGES]), .shift_i(shift), .head_o(d_head)
  );

  assign z_gen = z_combine(a_head, b_head, d_head);
  assign z_cur = wrap_pt ? z0_q : z_gen;

  qscr_chip_mapper u_map (
    .z_i(z_cur), .odd_i(idx_q[0]), .c2_hold_i(c2_hold_q),
    .i_bit_o(i_bit_o), .q_bit_o(q_bit_o),
    .c2_now_o(c2_now), .c2_used_o(c2_used)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      code_q    <= '0;
      z0_q      <= 2'd1;
      c2_hold_q <= 1'b0;
    end else begin
      if (load_i) code_q <= code_i;
      if (reload) begin
        idx_q <= '0;
        z0_q  <= z_seed;
      end else if (shift) begin
        idx_q <= idx_q + IDX_W'(1);
      end
      if (advance && !idx_q[0]) c2_hold_q <= c2_now;
    end
  end

  p_load_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (idx_q == '0) && (code_q == $past(code_i)));
  p_wrap_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && wrap_pt) |=> idx_q == '0);
  p_repeat_chip0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && wrap_pt) |=> z_cur == $past(z_cur));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !chip_en_i) |=> $stable(idx_q) && $stable(i_bit_o) && $stable(q_bit_o));
  p_c2_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !idx_q[0]) |=> c2_used == $past(c2_now));
endmodule

// File: tb/test_qscr_short_code_gen.sv
module test_qscr_short_code_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [23:0] code_i = '0;
  logic        chip_en_i = 1'b0;
  logic        i_bit_o, q_bit_o;

  always #2 clk = ~clk;  // 250 MHz

  qscr_short_code_gen i_qscr_short_code_gen (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .code_i(code_i),
    .chip_en_i(chip_en_i), .i_bit_o(i_bit_o), .q_bit_o(q_bit_o)
  );

  typedef struct {
    bit    ei;
    bit    eq;
    int    pos;
    string tag;
  } exp_t;

  exp_t q_exp[$];
  int   checks = 0;
  int   errors = 0;
  int   zr[256];
  int   pos = 0;
  bit   done = 0;

  // Model: expand the three recursions over whole arrays (R3, R4, R5, R6, R7).
  task automatic build_ref(input logic [23:0] n);
    int aa[255];
    int bb[255];
    int dd[255];
    for (int k = 0; k < 8; k++) begin
      aa[k] = (k == 0) ? (2 * n[0] + 1) % 4 : (2 * n[k]) % 4;
      bb[k] = n[8 + k];
      dd[k] = n[16 + k];
    end
    for (int k = 8; k < 255; k++) begin
      aa[k] = (3 * aa[k-3] + aa[k-5] + 3 * aa[k-6] + 2 * aa[k-7] + 3 * aa[k-8]) % 4;
      bb[k] = (bb[k-1] + bb[k-3] + bb[k-7] + bb[k-8]) % 2;
      dd[k] = (dd[k-1] + dd[k-3] + dd[k-4] + dd[k-8]) % 2;
    end
    for (int k = 0; k < 255; k++) zr[k] = (aa[k] + 2 * bb[k] + 2 * dd[k]) % 4;
    zr[255] = zr[0];
  endtask

  // R9/R12: c1 is -1 (bit 1) for 1 and 2. R10: c2 is -1 for 2 and 3.
  function automatic bit c1_of(input int z);
    return (z == 1) || (z == 2);
  endfunction
  function automatic bit c2_of(input int z);
    return z >= 2;
  endfunction

  task automatic push_exp(input string tag);
    exp_t e;
    e.ei  = c1_of(zr[pos]);
    e.eq  = c1_of(zr[pos]) ^ pos[0] ^ c2_of(zr[pos - pos % 2]);
    e.pos = pos;
    e.tag = (pos == 255) ? "R7" : tag;
    q_exp.push_back(e);
  endtask

  task automatic step(input bit ld, input logic [23:0] n, input bit en, input string tag);
    string t;
    @(negedge clk);
    load_i    = ld;
    code_i    = n;
    chip_en_i = en;
    t = tag;
    if (ld) begin
      build_ref(n);
      pos = 0;
    end else if (en) begin
      if (pos == 255) t = "R8";
      pos = (pos + 1) % 256;
    end else begin
      t = "R11";
    end
    push_exp(t);
  endtask

  // Monitor: one expected entry is due just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (rst_n && q_exp.size() > 0) begin
      exp_t e;
      e = q_exp.pop_front();
      checks++;
      if (i_bit_o !== e.ei) begin
        errors++;
        $display("FAIL %s/R9 chip %0d i_bit actual %b expected %b", e.tag, e.pos, i_bit_o, e.ei);
      end
      checks++;
      if (q_bit_o !== e.eq) begin
        errors++;
        $display("FAIL %s/R10 chip %0d q_bit actual %b expected %b", e.tag, e.pos, q_bit_o, e.eq);
      end
    end
  end

  initial begin
    build_ref(24'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pos = 0;
    push_exp("R1");  // reset state equals code 0, chip 0
    // R3: quaternary part only
    step(1, 24'h0000B5, 0, "R2");
    for (int k = 0; k < 258; k++) step(0, 24'h0, 1, "R3");
    // R4: first binary part only
    step(1, 24'h00C700, 0, "R2");
    for (int k = 0; k < 258; k++) step(0, 24'h0, 1, "R4");
    // R5: second binary part only
    step(1, 24'h5E0000, 0, "R2");
    for (int k = 0; k < 258; k++) step(0, 24'h0, 1, "R5");
    // R6: mixed code with enable gaps (R11 on idle cycles)
    step(1, 24'hA5C3F1, 0, "R2");
    for (int k = 0; k < 600; k++) step(0, 24'h0, (k % 3) != 0, "R6");
    // R2: load while enable is high, in mid-period
    step(1, 24'h123456, 1, "R2");
    for (int k = 0; k < 300; k++) step(0, 24'h0, 1, "R2");
    // R12: all-ones code, two full periods
    step(1, 24'hFFFFFF, 0, "R2");
    for (int k = 0; k < 520; k++) step(0, 24'h0, 1, "R12");
    for (int k = 0; k < 4; k++) step(0, 24'h0, 0, "R11");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule